// File: doc/BRIEF.md
# Word-to-Link Output Framer

This block sits between the demultiplexer of a switch's internal bus and a link transmitter. The switch delivers packets as wide bus words. The link accepts narrow slices, one slice per clock. The framer turns each bus word into a run of slices, sent most significant slice first.

A packet reaches the framer without its start-of-packet word, so the framer puts that word back in front of the payload. While idle, a holding register tracks the configured start pattern. When the output enable is seen, the holding register moves into the shift register, so the start pattern leaves first. From then on, the block takes a fresh bus word only on the edge where one word finishes and the next begins. That gives a fixed cadence of one capture per BUS_W/LINK_W cycles.

A request line tells the transmitter that slices are on the data lines. The request stays high until the last captured word has been fully sent.

Top module: `link_out_framer`

## Requirements
- R1: During reset and on the first cycle after it, `link_req` is 0 and `link_data` is 0.
- R2: While idle with `out_en` low, `link_req` stays 0 and `link_data` stays 0. The holding register reloads from `start_pat` on every idle edge, so a new pattern set while idle is used by the next packet.
- R3: An edge that samples `out_en` high while idle raises `link_req` for the following cycle. The first slice shown then is the top LINK_W bits of the start pattern held at that edge.
- R4: Each word goes out as RATIO = BUS_W/LINK_W slices of LINK_W bits, one per cycle, with bit BUS_W-1 down to BUS_W-LINK_W first. The word occupies exactly RATIO consecutive request cycles.
- R5: `bus_word` is captured only on capture edges: the launching edge, and each word-end edge that samples `out_en` high. The word captured on one capture edge is sent during the RATIO cycles after the next word-end edge. Values on `bus_word` at other edges have no effect.
- R6: `out_en` is sampled only when idle and on word-end edges. Lowering it in the middle of a word does not shorten or alter the stream.
- R7: A word-end edge that samples `out_en` low starts the tail. The last captured word is sent in full, then `link_req` and `link_data` return to 0. A packet with N captured words therefore holds `link_req` high for (N+1)*RATIO cycles.
- R8: Changes to `start_pat` while a packet is in flight do not alter the slices of that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_word | input | BUS_W | Word from the switch demultiplexer |
| out_en | input | 1 | Output enable; starts and sustains a packet |
| start_pat | input | BUS_W | Start-of-packet pattern to regenerate |
| link_data | output | LINK_W | Slice toward the link transmitter |
| link_req | output | 1 | High while a slice is valid on `link_data` |

## Verification
A word-end edge does two jobs in the same cycle. It moves the holding register into the shift register, and it either captures the next bus word or, if `out_en` is low, switches the holding register back to the start pattern. The bench provokes this by changing `bus_word` and `out_en` only on the cycle just before each boundary. It also drives decoy values on `bus_word` and dips `out_en` in mid-word. A scoreboard of expected slices then judges whether the right word left the shift register, whether any decoy leaked in, and whether the request fell exactly RATIO cycles after the final boundary.

// File: rtl/lof_pkg.sv
package lof_pkg;
   typedef enum logic [1:0] {
      LOF_IDLE = 2'd0,
      LOF_RUN  = 2'd1,
      LOF_TAIL = 2'd2
   } lof_state_e;

   typedef enum logic [1:0] {
      HOLD_KEEP = 2'd0,
      HOLD_BUS  = 2'd1,
      HOLD_PAT  = 2'd2
   } lof_hold_op_e;

   typedef enum logic [1:0] {
      SH_CLEAR = 2'd0,
      SH_LOAD  = 2'd1,
      SH_STEP  = 2'd2
   } lof_shift_op_e;
endpackage

// File: rtl/lof_pacer.sv
module lof_pacer #(
   parameter int RATIO = 4,
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   output logic [CNT_W-1:0] cnt,
   output logic             word_end
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(RATIO - 1);

   logic [CNT_W-1:0] cnt_q;

   assign word_end = run && (cnt_q == LAST);
   assign cnt      = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || word_end) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/lof_ctrl.sv
module lof_ctrl
   import lof_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          out_en,
   input  logic          word_end,
   output logic          run,
   output lof_hold_op_e  hold_op,
   output lof_shift_op_e shift_op
);
   lof_state_e state_q, state_d;

   always_comb begin
      state_d  = state_q;
      hold_op  = HOLD_KEEP;
      shift_op = SH_STEP;
      unique case (state_q)
         LOF_IDLE: begin
            if (out_en) begin
               state_d  = LOF_RUN;
               hold_op  = HOLD_BUS;
               shift_op = SH_LOAD;
            end else begin
               hold_op  = HOLD_PAT;
               shift_op = SH_CLEAR;
            end
         end
         LOF_RUN: begin
            if (word_end) begin
               shift_op = SH_LOAD;
               if (out_en) begin
                  hold_op = HOLD_BUS;
               end else begin
                  hold_op = HOLD_PAT;
                  state_d = LOF_TAIL;
               end
            end
         end
         LOF_TAIL: begin
            hold_op = HOLD_PAT;
            if (word_end) begin
               shift_op = SH_CLEAR;
               state_d  = LOF_IDLE;
            end
         end
         default: begin
            state_d  = LOF_IDLE;
            hold_op  = HOLD_PAT;
            shift_op = SH_CLEAR;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= LOF_IDLE;
      else        state_q <= state_d;
   end

   assign run = (state_q != LOF_IDLE);
endmodule

// File: rtl/lof_datapath.sv
module lof_datapath
   import lof_pkg::*;
#(
   parameter int BUS_W  = 16,
   parameter int LINK_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  lof_hold_op_e      hold_op,
   input  lof_shift_op_e     shift_op,
   input  logic [BUS_W-1:0]  bus_word,
   input  logic [BUS_W-1:0]  start_pat,
   output logic [BUS_W-1:0]  shift_o,
   output logic [LINK_W-1:0] link_data
);
   localparam int REST_W = BUS_W - LINK_W;

   logic [BUS_W-1:0] hold_q;
   logic [BUS_W-1:0] shift_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else begin
         unique case (hold_op)
            HOLD_BUS: hold_q <= bus_word;
            HOLD_PAT: hold_q <= start_pat;
            default:  hold_q <= hold_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shift_q <= '0;
      end else begin
         unique case (shift_op)
            SH_LOAD: shift_q <= hold_q;
            SH_STEP: shift_q <= {shift_q[REST_W-1:0], {LINK_W{1'b0}}};
            default: shift_q <= '0;
         endcase
      end
   end

   assign link_data = shift_q[BUS_W-1 -: LINK_W];
   assign shift_o   = shift_q;
endmodule

// File: rtl/link_out_framer.sv
module link_out_framer
   import lof_pkg::*;
#(
   parameter int BUS_W  = 16,
   parameter int LINK_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BUS_W-1:0]  bus_word,
   input  logic              out_en,
   input  logic [BUS_W-1:0]  start_pat,
   output logic [LINK_W-1:0] link_data,
   output logic              link_req
);
   localparam int RATIO = BUS_W / LINK_W;
   localparam int CNT_W = (RATIO > 1) ? $clog2(RATIO) : 1;

   generate
      if ((BUS_W % LINK_W) != 0) begin : g_bad_div
         $error("link_out_framer: BUS_W must be a multiple of LINK_W");
      end
      if (RATIO < 2) begin : g_bad_ratio
         $error("link_out_framer: BUS_W must be at least twice LINK_W");
      end
   endgenerate

   logic          run_w;
   logic          word_end_w;
   logic [CNT_W-1:0] cnt_w;
   logic [BUS_W-1:0] shift_w;
   lof_hold_op_e  hold_op_w;
   lof_shift_op_e shift_op_w;

   lof_pacer #(.RATIO(RATIO), .CNT_W(CNT_W)) pacer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_w),
      .cnt      (cnt_w),
      .word_end (word_end_w)
   );

   lof_ctrl ctrl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .out_en   (out_en),
      .word_end (word_end_w),
      .run      (run_w),
      .hold_op  (hold_op_w),
      .shift_op (shift_op_w)
   );

   lof_datapath #(.BUS_W(BUS_W), .LINK_W(LINK_W)) dp_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold_op   (hold_op_w),
      .shift_op  (shift_op_w),
      .bus_word  (bus_word),
      .start_pat (start_pat),
      .shift_o   (shift_w),
      .link_data (link_data)
   );

   assign link_req = run_w;
endmodule

// File: rtl/link_out_framer_chk.sv
module link_out_framer_chk #(
   parameter int BUS_W  = 16,
   parameter int LINK_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              out_en,
   input logic              link_req,
   input logic [LINK_W-1:0] link_data,
   input logic [((BUS_W/LINK_W) > 1 ? $clog2(BUS_W/LINK_W) : 1)-1:0] cnt,
   input logic [BUS_W-1:0]  shift_q
);
   localparam int RATIO = BUS_W / LINK_W;
   localparam int CNT_W = (RATIO > 1) ? $clog2(RATIO) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(RATIO - 1);

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!link_req && !out_en) |=> (!link_req && link_data == '0));

   // R3
   launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!link_req && out_en) |=> link_req);

   // R4
   msb_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (link_req && cnt != '0) |-> link_data == $past(shift_q[BUS_W-LINK_W-1 -: LINK_W]));

   // R4
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);

   // R6
   mid_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (link_req && cnt != LAST) |=> link_req);

   // R7
   end_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(link_req) |-> $past(cnt) == LAST);
endmodule

bind link_out_framer link_out_framer_chk #(.BUS_W(BUS_W), .LINK_W(LINK_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .out_en    (out_en),
   .link_req  (link_req),
   .link_data (link_data),
   .cnt       (cnt_w),
   .shift_q   (shift_w)
);

// File: tb/link_out_framer_tb_top.sv
`timescale 1ns/1ps
module link_out_framer_tb_top;
   localparam int BUS_W  = 16;
   localparam int LINK_W = 4;
   localparam int RATIO  = BUS_W / LINK_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [BUS_W-1:0]  bus_word = '0;
   logic              out_en = 1'b0;
   logic [BUS_W-1:0]  start_pat = 16'hA5C3;
   logic [LINK_W-1:0] link_data;
   logic              link_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [LINK_W-1:0] exp_q[$];

   always #5 clk = ~clk;

   link_out_framer #(.BUS_W(BUS_W), .LINK_W(LINK_W)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_word  (bus_word),
      .out_en    (out_en),
      .start_pat (start_pat),
      .link_data (link_data),
      .link_req  (link_req)
   );

   task automatic push_word(input logic [BUS_W-1:0] w);
      for (int s = RATIO - 1; s >= 0; s--) exp_q.push_back(w[s*LINK_W +: LINK_W]);
   endtask

   // Monitor: pops one expected slice per request cycle (R4, R5, R6, R8).
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (link_req) begin
            if (exp_q.size() == 0) begin
               errors++;
               $display("FAIL R7: request high with nothing expected, data=%h expected idle", link_data);
            end else begin
               logic [LINK_W-1:0] e;
               e = exp_q.pop_front();
               if (link_data !== e) begin
                  errors++;
                  $display("FAIL R4/R5: slice actual=%h expected=%h", link_data, e);
               end
            end
         end else if (link_data !== '0) begin
            errors++;
            $display("FAIL R2: idle data actual=%h expected=0", link_data);
         end
      end
   end

   task automatic end_check(input string tag);
      checks++;
      if (link_req !== 1'b0 || link_data !== '0 || exp_q.size() != 0) begin
         errors++;
         $display("FAIL %s: end of packet req=%b data=%h left=%0d expected req=0 data=0 left=0",
                  tag, link_req, link_data, exp_q.size());
      end
   endtask

   task automatic send_packet(input int nwords, input logic [BUS_W-1:0] base,
                              input bit glitch, input bit pat_change);
      push_word(start_pat);
      for (int k = 0; k < nwords; k++) begin
         logic [BUS_W-1:0] w;
         w = base + BUS_W'(k) * 16'h1357;
         @(negedge clk);
         bus_word = w;
         out_en   = 1'b1;
         push_word(w);
         if (k == 0 && pat_change) start_pat = ~start_pat;   // R8
         for (int j = 0; j < RATIO - 1; j++) begin
            @(negedge clk);
            bus_word = ~w;                                   // R5 decoy
            if (glitch && j == 0) out_en = 1'b0;             // R6 dip
            if (glitch && j == 1) out_en = 1'b1;
         end
      end
      @(negedge clk);
      out_en   = 1'b0;
      bus_word = 16'hDEAD;
      repeat (RATIO) @(negedge clk);
      @(negedge clk);
      end_check("R7");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (link_req !== 1'b0 || link_data !== '0) begin
         errors++;
         $display("FAIL R1: in reset req=%b data=%h expected 0 0", link_req, link_data);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (link_req !== 1'b0 || link_data !== '0) begin
         errors++;
         $display("FAIL R1: after reset req=%b data=%h expected 0 0", link_req, link_data);
      end
      repeat (2) @(negedge clk);
      // R3 R4 R5 R7: plain three-word packet
      send_packet(3, 16'h1234, 1'b0, 1'b0);
      // R7: shortest packet, one word
      send_packet(1, 16'hBEEF, 1'b0, 1'b0);
      // R6: out_en dips mid-word
      send_packet(4, 16'h0F0F, 1'b1, 1'b0);
      // R2: new pattern while idle used by next packet
      start_pat = 16'h7E81;
      repeat (3) @(negedge clk);
      send_packet(2, 16'hC001, 1'b0, 1'b0);
      // R8: pattern changes after launch
      send_packet(3, 16'h4242, 1'b0, 1'b1);
      // R2: long idle stays quiet
      repeat (10) @(negedge clk);
      end_check("R2");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog: run did not end, actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule